// File: doc/BRIEF.md
# Debug Access Authorization Router

The router stands between the memory-access ports of an external debug adapter and two targets. The first target is the debug-unit register bus, a single-cycle APB-style bus. The second is the CPU bus system, which has one debug port per CPU. Each request carries a port number, an address, a direction and write data.

For port 0, the router sorts the address into one of four regions:
- the internal window of the debug-unit space,
- the external window of the debug-unit space,
- the private peripheral / IO bus,
- all other memory.

The router then forwards the request or refuses it, according to the 2-bit debugger access level of the CPU that owns the port. A refused request completes at once with an error and zero read data. One case is different: at level 1, an internal-window access goes forward marked non-secure, so the debug unit ignores it, and the router raises a sticky protection-error flag.

The router also gates debugger attach. A cold-plug request is always granted. The first cold plug unlocks port 0. A hot-plug request is granted only when CPU0 is at level 1 or 2.

Each accepted request takes exactly one target cycle. A permitted request drives a one-cycle strobe on its target in the cycle after acceptance, and the response appears one cycle later. A request that arrives while a strobe is active is not taken.

Top module: `dar_router`

## Requirements
- R1: Port-0 addresses from DBU_BASE up to DBU_BASE+0x1FFF go to the debug-unit bus with the offset from DBU_BASE as address. All other permitted port-0 addresses go to the CPU bus with cpu_port_o = 0. The strobe is high for the single cycle after acceptance. The following cycle has rsp_valid_o high, with rsp_err_o and rsp_rdata_o copied from that target's response.
- R2: When the CPU0 level is 2 (binary 10, bits [1:0] of dbg_level_i), port 0 reaches all four regions. Every access is marked secure (dbu_nsec_o = 0).
- R3: When the CPU0 level is 0 or 3, port 0 may reach only the external window (offsets 0x100 to 0x1FFF). Any other port-0 request raises no strobe. It completes in the cycle after acceptance with rsp_err_o = 1 and rsp_rdata_o = 0.
- R4: When the CPU0 level is 1, port 0 reaches the external window, the private region and other memory as secure accesses. An internal-window access (offsets 0x000 to 0x0FF) is forwarded with dbu_nsec_o = 1 and sets prot_err_o.
- R5: prot_err_o stays set until a secure, permitted port-0 write to internal offset STAT_OFS (0) with write-data bit PERR_BIT (0) equal to 1 clears it. The same write refused at level 0 leaves it set.
- R6: For a port x > 0, the level in bits [2x+1:2x] of dbg_level_i decides. Level 0 makes every request an error. Any other level forwards the request to the CPU bus with cpu_port_o = x, with no region check. A port number of NPORT or above is always refused.
- R7: Port 0 refuses every request until a cold plug has been granted. port0_en_o shows the unlock, and it stays set until reset.
- R8: cold_ack_o pulses one cycle after every cold_plug_i, whatever the level. hot_ack_o pulses one cycle after hot_plug_i only if the CPU0 level is 1 or 2.
- R9: The level is sampled in the acceptance cycle. Changing dbg_level_i after acceptance does not alter the routing or the response of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbg_level_i | input | 2*NPORT | Access level per CPU, 2 bits each, CPU0 in the low bits |
| cold_plug_i | input | 1 | Cold-plug attach request |
| hot_plug_i | input | 1 | Hot-plug attach request |
| cold_ack_o | output | 1 | Cold-plug granted (pulse) |
| hot_ack_o | output | 1 | Hot-plug granted (pulse) |
| port0_en_o | output | 1 | Port 0 unlocked by a cold plug |
| req_valid_i | input | 1 | Request valid |
| req_port_i | input | PW | Requesting access port |
| req_addr_i | input | AW | Request address |
| req_write_i | input | 1 | 1 = write |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | Response valid (pulse) |
| rsp_err_o | output | 1 | Response carries a bus error |
| rsp_rdata_o | output | DW | Response read data |
| dbu_sel_o | output | 1 | Debug-unit bus strobe |
| dbu_write_o | output | 1 | Debug-unit bus direction |
| dbu_addr_o | output | OFS_W | Offset within the debug-unit space |
| dbu_wdata_o | output | DW | Debug-unit write data |
| dbu_nsec_o | output | 1 | Transfer is non-secure; the debug unit ignores internal accesses so marked |
| dbu_rdata_i | input | DW | Debug-unit read data |
| dbu_err_i | input | 1 | Debug-unit error |
| cpu_sel_o | output | 1 | CPU bus strobe |
| cpu_write_o | output | 1 | CPU bus direction |
| cpu_port_o | output | PW | CPU debug port addressed |
| cpu_addr_o | output | AW | CPU bus address |
| cpu_wdata_o | output | DW | CPU bus write data |
| cpu_rdata_i | input | DW | CPU bus read data |
| cpu_err_i | input | 1 | CPU bus error |
| prot_err_o | output | 1 | Sticky protection-error flag |

## Verification
The bench builds the router with NPORT = 3, which makes the port field 2 bits wide. A second secondary port (port 2) can then be checked for independence from port 1. Port number 3 also becomes reachable as an out-of-range request that must be refused. The address windows keep their default values, so every region has a fixed probe address and expected read data can be derived from the address alone.

// File: rtl/dar_pkg.sv
package dar_pkg;

    typedef enum logic [1:0] {
        RG_INT   = 2'd0,
        RG_EXT   = 2'd1,
        RG_PRIV  = 2'd2,
        RG_OTHER = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ACT_DENY = 2'd0,
        ACT_DBU  = 2'd1,
        ACT_CPU  = 2'd2
    } action_e;

    typedef struct packed {
        action_e act;
        logic    nsec;
    } verdict_t;

endpackage

// File: rtl/dar_decode.sv
module dar_decode
    import dar_pkg::*;
#(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  DBU_BASE  = 32'h4100_2000,
    parameter int             DBU_SPAN  = 8192,
    parameter int             INT_SPAN  = 256,
    parameter logic [AW-1:0]  PPB_BASE  = 32'hE000_0000,
    parameter logic [AW-1:0]  PPB_SPAN  = 32'h0010_0000,
    parameter logic [AW-1:0]  IOB_BASE  = 32'h6000_0000,
    parameter logic [AW-1:0]  IOB_SPAN  = 32'h0010_0000,
    localparam int            OFS_W     = $clog2(DBU_SPAN)
) (
    input  logic [AW-1:0]    addr_i,
    output region_e          region_o,
    output logic [OFS_W-1:0] ofs_o
);

    logic [AW-1:0] dbu_diff, ppb_diff, iob_diff;
    logic          in_dbu, in_ppb, in_iob;

    always_comb begin
        dbu_diff = addr_i - DBU_BASE;
        ppb_diff = addr_i - PPB_BASE;
        iob_diff = addr_i - IOB_BASE;
        in_dbu   = (addr_i >= DBU_BASE) && (dbu_diff < AW'(DBU_SPAN));
        in_ppb   = (addr_i >= PPB_BASE) && (ppb_diff < PPB_SPAN);
        in_iob   = (addr_i >= IOB_BASE) && (iob_diff < IOB_SPAN);
        ofs_o    = dbu_diff[OFS_W-1:0];

        if (in_dbu && (dbu_diff < AW'(INT_SPAN))) region_o = RG_INT;
        else if (in_dbu)                         region_o = RG_EXT;
        else if (in_ppb || in_iob)               region_o = RG_PRIV;
        else                                     region_o = RG_OTHER;
    end

endmodule

// File: rtl/dar_policy.sv
module dar_policy
    import dar_pkg::*;
#(
    parameter int  NPORT = 2,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [2*NPORT-1:0] lvl_i,
    input  logic [PW-1:0]      port_i,
    input  region_e            region_i,
    input  logic               port0_en_i,
    output verdict_t           verdict_o
);

    logic [1:0] lvl_a [NPORT];

    for (genvar g = 0; g < NPORT; g++) begin : g_lvl
        assign lvl_a[g] = lvl_i[2*g +: 2];
    end

    logic [1:0] lvl_sel;

    always_comb begin
        lvl_sel = 2'd0;
        for (int i = 0; i < NPORT; i++) begin
            if (int'(port_i) == i) lvl_sel = lvl_a[i];
        end
    end

    always_comb begin
        verdict_o.act  = ACT_DENY;
        verdict_o.nsec = 1'b0;
        if (port_i == '0) begin
            if (port0_en_i) begin
                unique case (lvl_sel)
                    2'd2: verdict_o.act =
                        (region_i == RG_INT || region_i == RG_EXT) ? ACT_DBU : ACT_CPU;
                    2'd1: begin
                        if (region_i == RG_INT) begin
                            verdict_o.act  = ACT_DBU;
                            verdict_o.nsec = 1'b1;
                        end else if (region_i == RG_EXT) begin
                            verdict_o.act = ACT_DBU;
                        end else begin
                            verdict_o.act = ACT_CPU;
                        end
                    end
                    default: begin
                        if (region_i == RG_EXT) verdict_o.act = ACT_DBU;
                    end
                endcase
            end
        end else if (int'(port_i) < NPORT) begin
            if (lvl_sel != 2'd0) verdict_o.act = ACT_CPU;
        end
    end

    // R4: only a level-1 port-0 internal access is marked non-secure
    always_comb begin
        if (verdict_o.nsec) begin
            a_nsec_only_l1_r4 : assert (port_i == '0 && lvl_sel == 2'd1 && region_i == RG_INT);
        end
    end

endmodule

// File: rtl/dar_attach.sv
module dar_attach (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] lvl0_i,
    input  logic       cold_plug_i,
    input  logic       hot_plug_i,
    output logic       cold_ack_o,
    output logic       hot_ack_o,
    output logic       port0_en_o
);

    typedef struct packed {
        logic port0_en;
        logic cold_ack;
        logic hot_ack;
    } att_t;

    att_t att_d, att_q;

    always_comb begin
        att_d          = att_q;
        att_d.cold_ack = cold_plug_i;
        att_d.hot_ack  = hot_plug_i && (lvl0_i == 2'd1 || lvl0_i == 2'd2);
        if (cold_plug_i) att_d.port0_en = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) att_q <= '0;
        else         att_q <= att_d;
    end

    assign cold_ack_o = att_q.cold_ack;
    assign hot_ack_o  = att_q.hot_ack;
    assign port0_en_o = att_q.port0_en;

    p_hot_gate_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        hot_ack_o |-> $past(lvl0_i == 2'd1 || lvl0_i == 2'd2));

    p_cold_always_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        cold_plug_i |=> cold_ack_o);

    p_unlock_sticky_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        port0_en_o |=> port0_en_o);

endmodule

// File: rtl/dar_router.sv
module dar_router
    import dar_pkg::*;
#(
    parameter int             NPORT     = 2,
    parameter int             AW        = 32,
    parameter int             DW        = 32,
    parameter logic [AW-1:0]  DBU_BASE  = 32'h4100_2000,
    parameter int             DBU_SPAN  = 8192,
    parameter int             INT_SPAN  = 256,
    parameter logic [AW-1:0]  PPB_BASE  = 32'hE000_0000,
    parameter logic [AW-1:0]  PPB_SPAN  = 32'h0010_0000,
    parameter logic [AW-1:0]  IOB_BASE  = 32'h6000_0000,
    parameter logic [AW-1:0]  IOB_SPAN  = 32'h0010_0000,
    parameter int             STAT_OFS  = 0,
    parameter int             PERR_BIT  = 0,
    localparam int            PW        = (NPORT > 1) ? $clog2(NPORT) : 1,
    localparam int            OFS_W     = $clog2(DBU_SPAN)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [2*NPORT-1:0] dbg_level_i,
    input  logic               cold_plug_i,
    input  logic               hot_plug_i,
    output logic               cold_ack_o,
    output logic               hot_ack_o,
    output logic               port0_en_o,
    input  logic               req_valid_i,
    input  logic [PW-1:0]      req_port_i,
    input  logic [AW-1:0]      req_addr_i,
    input  logic               req_write_i,
    input  logic [DW-1:0]      req_wdata_i,
    output logic               rsp_valid_o,
    output logic               rsp_err_o,
    output logic [DW-1:0]      rsp_rdata_o,
    output logic               dbu_sel_o,
    output logic               dbu_write_o,
    output logic [OFS_W-1:0]   dbu_addr_o,
    output logic [DW-1:0]      dbu_wdata_o,
    output logic               dbu_nsec_o,
    input  logic [DW-1:0]      dbu_rdata_i,
    input  logic               dbu_err_i,
    output logic               cpu_sel_o,
    output logic               cpu_write_o,
    output logic [PW-1:0]      cpu_port_o,
    output logic [AW-1:0]      cpu_addr_o,
    output logic [DW-1:0]      cpu_wdata_o,
    input  logic [DW-1:0]      cpu_rdata_i,
    input  logic               cpu_err_i,
    output logic               prot_err_o
);

    region_e          region;
    logic [OFS_W-1:0] ofs;
    verdict_t         verdict;

    dar_decode #(
        .AW(AW), .DBU_BASE(DBU_BASE), .DBU_SPAN(DBU_SPAN), .INT_SPAN(INT_SPAN),
        .PPB_BASE(PPB_BASE), .PPB_SPAN(PPB_SPAN),
        .IOB_BASE(IOB_BASE), .IOB_SPAN(IOB_SPAN)
    ) i_decode (
        .addr_i   (req_addr_i),
        .region_o (region),
        .ofs_o    (ofs)
    );

    dar_policy #(.NPORT(NPORT)) i_policy (
        .lvl_i      (dbg_level_i),
        .port_i     (req_port_i),
        .region_i   (region),
        .port0_en_i (port0_en_o),
        .verdict_o  (verdict)
    );

    dar_attach i_attach (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lvl0_i      (dbg_level_i[1:0]),
        .cold_plug_i (cold_plug_i),
        .hot_plug_i  (hot_plug_i),
        .cold_ack_o  (cold_ack_o),
        .hot_ack_o   (hot_ack_o),
        .port0_en_o  (port0_en_o)
    );

    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_err;
        logic [DW-1:0]    rsp_rdata;
        logic             dbu_sel;
        logic             dbu_write;
        logic             dbu_nsec;
        logic [OFS_W-1:0] dbu_addr;
        logic [DW-1:0]    dbu_wdata;
        logic             cpu_sel;
        logic             cpu_write;
        logic [PW-1:0]    cpu_port;
        logic [AW-1:0]    cpu_addr;
        logic [DW-1:0]    cpu_wdata;
        logic             perr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_rdata = '0;
        st_d.dbu_sel   = 1'b0;
        st_d.cpu_sel   = 1'b0;

        if (st_q.dbu_sel) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_err   = dbu_err_i;
            st_d.rsp_rdata = dbu_rdata_i;
        end else if (st_q.cpu_sel) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_err   = cpu_err_i;
            st_d.rsp_rdata = cpu_rdata_i;
        end else if (req_valid_i) begin
            unique case (verdict.act)
                ACT_DBU: begin
                    st_d.dbu_sel   = 1'b1;
                    st_d.dbu_write = req_write_i;
                    st_d.dbu_addr  = ofs;
                    st_d.dbu_wdata = req_wdata_i;
                    st_d.dbu_nsec  = verdict.nsec;
                    if (verdict.nsec) begin
                        st_d.perr = 1'b1;
                    end else if (req_write_i && ofs == OFS_W'(STAT_OFS)
                                 && req_wdata_i[PERR_BIT]) begin
                        st_d.perr = 1'b0;
                    end
                end
                ACT_CPU: begin
                    st_d.cpu_sel   = 1'b1;
                    st_d.cpu_write = req_write_i;
                    st_d.cpu_port  = req_port_i;
                    st_d.cpu_addr  = req_addr_i;
                    st_d.cpu_wdata = req_wdata_i;
                end
                default: begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_err_o   = st_q.rsp_err;
    assign rsp_rdata_o = st_q.rsp_rdata;
    assign dbu_sel_o   = st_q.dbu_sel;
    assign dbu_write_o = st_q.dbu_write;
    assign dbu_addr_o  = st_q.dbu_addr;
    assign dbu_wdata_o = st_q.dbu_wdata;
    assign dbu_nsec_o  = st_q.dbu_nsec;
    assign cpu_sel_o   = st_q.cpu_sel;
    assign cpu_write_o = st_q.cpu_write;
    assign cpu_port_o  = st_q.cpu_port;
    assign cpu_addr_o  = st_q.cpu_addr;
    assign cpu_wdata_o = st_q.cpu_wdata;
    assign prot_err_o  = st_q.perr;

    p_one_target_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dbu_sel_o && cpu_sel_o));

    p_strobe_then_rsp_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbu_sel_o || cpu_sel_o) |=> (rsp_valid_o && !dbu_sel_o && !cpu_sel_o));

    p_deny_zero_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !$past(dbu_sel_o || cpu_sel_o)) |-> (rsp_err_o && rsp_rdata_o == '0));

    p_nsec_internal_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbu_sel_o && dbu_nsec_o) |-> (dbu_addr_o < OFS_W'(INT_SPAN) && prot_err_o));

    p_perr_clear_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(prot_err_o) |-> $past(req_valid_i && req_write_i && req_port_i == '0));

    p_dbu_needs_unlock_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbu_sel_o |-> port0_en_o);

endmodule

// File: tb/test_dar_router.sv
module test_dar_router;

    localparam int NPORT = 3;
    localparam int PW    = 2;
    localparam int OFS_W = 13;

    localparam logic [31:0] A_INT = 32'h4100_2010;
    localparam logic [31:0] A_STA = 32'h4100_2000;
    localparam logic [31:0] A_EXT = 32'h4100_2400;
    localparam logic [31:0] A_PPB = 32'hE000_E000;
    localparam logic [31:0] A_IOB = 32'h6000_0040;
    localparam logic [31:0] A_OTH = 32'h2000_0000;

    localparam logic [1:0] K_DENY = 2'd0;
    localparam logic [1:0] K_DBU  = 2'd1;
    localparam logic [1:0] K_CPU  = 2'd2;

    typedef struct packed {
        logic [5:0]  lvl;
        logic [1:0]  port;
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  kind;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        // R2: level 2 reaches every region
        '{6'b10_10_10, 2'd0, A_INT, 1'b0, K_DBU,  4'd2},
        '{6'b10_10_10, 2'd0, A_EXT, 1'b1, K_DBU,  4'd2},
        '{6'b10_10_10, 2'd0, A_PPB, 1'b0, K_CPU,  4'd2},
        '{6'b10_10_10, 2'd0, A_OTH, 1'b1, K_CPU,  4'd2},
        // R3: level 0 external window only
        '{6'b10_10_00, 2'd0, A_INT, 1'b0, K_DENY, 4'd3},
        '{6'b10_10_00, 2'd0, A_EXT, 1'b0, K_DBU,  4'd3},
        '{6'b10_10_00, 2'd0, A_PPB, 1'b1, K_DENY, 4'd3},
        '{6'b10_10_00, 2'd0, A_IOB, 1'b0, K_DENY, 4'd3},
        '{6'b10_10_00, 2'd0, A_OTH, 1'b0, K_DENY, 4'd3},
        // R3: level 3 same as level 0
        '{6'b10_10_11, 2'd0, A_INT, 1'b1, K_DENY, 4'd3},
        '{6'b10_10_11, 2'd0, A_EXT, 1'b1, K_DBU,  4'd3},
        '{6'b10_10_11, 2'd0, A_OTH, 1'b0, K_DENY, 4'd3},
        // R4: level 1 non-internal regions
        '{6'b10_10_01, 2'd0, A_EXT, 1'b0, K_DBU,  4'd4},
        '{6'b10_10_01, 2'd0, A_PPB, 1'b1, K_CPU,  4'd4},
        '{6'b10_10_01, 2'd0, A_IOB, 1'b0, K_CPU,  4'd4},
        '{6'b10_10_01, 2'd0, A_OTH, 1'b0, K_CPU,  4'd4},
        // R6: secondary ports
        '{6'b10_00_10, 2'd1, A_OTH, 1'b0, K_DENY, 4'd6},
        '{6'b10_01_10, 2'd1, A_OTH, 1'b1, K_CPU,  4'd6},
        '{6'b10_11_10, 2'd1, A_INT, 1'b0, K_CPU,  4'd6},
        '{6'b10_00_10, 2'd2, A_PPB, 1'b0, K_CPU,  4'd6},
        '{6'b00_10_10, 2'd2, A_OTH, 1'b0, K_DENY, 4'd6},
        '{6'b10_10_10, 2'd3, A_OTH, 1'b0, K_DENY, 4'd6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        lvl = '0;
    logic              cold = 1'b0, hot = 1'b0;
    logic              cold_ack, hot_ack, p0_en;
    logic              req_valid = 1'b0;
    logic [PW-1:0]     req_port = '0;
    logic [31:0]       req_addr = '0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;
    logic              dbu_sel, dbu_write, dbu_nsec;
    logic [OFS_W-1:0]  dbu_addr;
    logic [31:0]       dbu_wdata, dbu_rdata;
    logic              dbu_err = 1'b0;
    logic              cpu_sel, cpu_write;
    logic [PW-1:0]     cpu_port;
    logic [31:0]       cpu_addr, cpu_wdata, cpu_rdata;
    logic              cpu_err = 1'b0;
    logic              perr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    assign dbu_rdata = 32'hD000_0000 | {19'b0, dbu_addr};
    assign cpu_rdata = cpu_addr ^ 32'h5A5A_0000;

    dar_router #(.NPORT(NPORT)) i_dar_router (
        .clk_i(clk), .rst_ni(rst_n), .dbg_level_i(lvl),
        .cold_plug_i(cold), .hot_plug_i(hot),
        .cold_ack_o(cold_ack), .hot_ack_o(hot_ack), .port0_en_o(p0_en),
        .req_valid_i(req_valid), .req_port_i(req_port), .req_addr_i(req_addr),
        .req_write_i(req_write), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
        .dbu_sel_o(dbu_sel), .dbu_write_o(dbu_write), .dbu_addr_o(dbu_addr),
        .dbu_wdata_o(dbu_wdata), .dbu_nsec_o(dbu_nsec),
        .dbu_rdata_i(dbu_rdata), .dbu_err_i(dbu_err),
        .cpu_sel_o(cpu_sel), .cpu_write_o(cpu_write), .cpu_port_o(cpu_port),
        .cpu_addr_o(cpu_addr), .cpu_wdata_o(cpu_wdata),
        .cpu_rdata_i(cpu_rdata), .cpu_err_i(cpu_err),
        .prot_err_o(perr)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic txn(input logic [5:0] lv, input logic [1:0] port, input logic [31:0] addr,
                       input logic wr, input logic [31:0] wd, input logic [1:0] kind,
                       input logic exp_nsec, input logic [5:0] lv_after, input string rq);
        logic [31:0] exp_rd;
        logic        exp_er;
        @(negedge clk);
        lvl = lv; req_port = port; req_addr = addr; req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lvl = lv_after;
        if (kind == K_DENY) begin
            chk(rsp_valid && rsp_err, rq, "deny response", {30'b0, rsp_valid, rsp_err}, 32'h3);
            chk(rsp_rdata == 32'h0, rq, "deny rdata", rsp_rdata, 32'h0);
            chk(!dbu_sel && !cpu_sel, rq, "deny no strobe", {30'b0, dbu_sel, cpu_sel}, 32'h0);
        end else begin
            if (kind == K_DBU) begin
                chk(dbu_sel && !cpu_sel, rq, "dbu strobe", {30'b0, dbu_sel, cpu_sel}, 32'h2);
                chk(dbu_addr == 13'(addr - 32'h4100_2000), rq, "dbu offset",
                    {19'b0, dbu_addr}, addr - 32'h4100_2000);
                chk(dbu_nsec == exp_nsec && dbu_write == wr, rq, "dbu attr",
                    {30'b0, dbu_nsec, dbu_write}, {30'b0, exp_nsec, wr});
                exp_rd = 32'hD000_0000 | (addr - 32'h4100_2000);
                exp_er = dbu_err;
            end else begin
                chk(cpu_sel && !dbu_sel, rq, "cpu strobe", {30'b0, cpu_sel, dbu_sel}, 32'h2);
                chk(cpu_addr == addr && cpu_port == port && cpu_write == wr, rq, "cpu fields",
                    cpu_addr, addr);
                exp_rd = addr ^ 32'h5A5A_0000;
                exp_er = cpu_err;
            end
            chk(!rsp_valid, rq, "no early rsp", {31'b0, rsp_valid}, 32'h0);
            @(negedge clk);
            chk(rsp_valid && rsp_err == exp_er, rq, "response",
                {30'b0, rsp_valid, rsp_err}, {30'b0, 1'b1, exp_er});
            chk(rsp_rdata == exp_rd, rq, "rdata", rsp_rdata, exp_rd);
            chk(!dbu_sel && !cpu_sel, rq, "strobe single", {30'b0, dbu_sel, cpu_sel}, 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(!rsp_valid && !dbu_sel && !cpu_sel && !perr && !p0_en && !cold_ack && !hot_ack,
            "R7", "reset state",
            {25'b0, rsp_valid, dbu_sel, cpu_sel, perr, p0_en, cold_ack, hot_ack}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: port 0 locked before cold plug, even at level 2
        txn(6'b10_10_10, 2'd0, A_EXT, 1'b0, 32'h0, K_DENY, 1'b0, 6'b10_10_10, "R7");
        // R8: hot plug refused at level 0, granted at level 1
        lvl = 6'b10_10_00; hot = 1'b1;
        @(negedge clk); hot = 1'b0;
        chk(!hot_ack, "R8", "hot plug level0", {31'b0, hot_ack}, 32'h0);
        lvl = 6'b10_10_11; hot = 1'b1;
        @(negedge clk); hot = 1'b0;
        chk(!hot_ack, "R8", "hot plug level3", {31'b0, hot_ack}, 32'h0);
        lvl = 6'b10_10_01; hot = 1'b1;
        @(negedge clk); hot = 1'b0;
        chk(hot_ack, "R8", "hot plug level1", {31'b0, hot_ack}, 32'h1);
        lvl = 6'b10_10_00; cold = 1'b1;
        @(negedge clk); cold = 1'b0;
        chk(cold_ack && p0_en, "R8", "cold plug level0", {30'b0, cold_ack, p0_en}, 32'h3);
        @(negedge clk);
        chk(p0_en && !cold_ack, "R7", "unlock sticky", {30'b0, p0_en, cold_ack}, 32'h2);

        // vector table (R2 R3 R4 R6)
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d[v%0d]", VECS[i].rq, i);
            txn(VECS[i].lvl, VECS[i].port, VECS[i].addr, VECS[i].wr, 32'hCAFE_0000,
                VECS[i].kind, 1'b0, VECS[i].lvl, tag);
        end
        chk(!perr, "R4", "no perr from table", {31'b0, perr}, 32'h0);

        // R4: level 1 internal write forwarded non-secure, sets perr
        txn(6'b10_10_01, 2'd0, A_INT, 1'b1, 32'h1, K_DBU, 1'b1, 6'b10_10_01, "R4");
        chk(perr, "R4", "perr set", {31'b0, perr}, 32'h1);
        // R5: sticky across other traffic; refused clear has no effect
        txn(6'b10_10_10, 2'd0, A_EXT, 1'b1, 32'h1, K_DBU, 1'b0, 6'b10_10_10, "R5");
        txn(6'b10_10_00, 2'd0, A_STA, 1'b1, 32'h1, K_DENY, 1'b0, 6'b10_10_00, "R5");
        chk(perr, "R5", "perr held", {31'b0, perr}, 32'h1);
        txn(6'b10_10_10, 2'd0, A_STA, 1'b1, 32'h0, K_DBU, 1'b0, 6'b10_10_10, "R5");
        chk(perr, "R5", "perr held on zero bit", {31'b0, perr}, 32'h1);
        txn(6'b10_10_10, 2'd0, A_STA, 1'b1, 32'h1, K_DBU, 1'b0, 6'b10_10_10, "R5");
        chk(!perr, "R5", "perr cleared", {31'b0, perr}, 32'h0);

        // R1: target error passes through
        cpu_err = 1'b1;
        txn(6'b10_10_10, 2'd0, A_OTH, 1'b0, 32'h0, K_CPU, 1'b0, 6'b10_10_10, "R1");
        cpu_err = 1'b0;
        dbu_err = 1'b1;
        txn(6'b10_10_10, 2'd0, A_EXT, 1'b0, 32'h0, K_DBU, 1'b0, 6'b10_10_10, "R1");
        dbu_err = 1'b0;

        // R9: level drop after acceptance leaves the request intact
        txn(6'b10_10_10, 2'd0, A_INT, 1'b0, 32'h0, K_DBU, 1'b0, 6'b10_10_00, "R9");
        txn(6'b10_01_10, 2'd1, A_OTH, 1'b0, 32'h0, K_CPU, 1'b0, 6'b10_00_10, "R9");
        // R9: level raise after acceptance does not rescue a refused one
        txn(6'b10_10_00, 2'd0, A_OTH, 1'b0, 32'h0, K_DENY, 1'b0, 6'b10_10_10, "R9");
        chk(!perr, "R9", "perr untouched", {31'b0, perr}, 32'h0);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule